// File: doc/BRIEF.md
# Serial Configuration EEPROM Boot Reader

This block fetches a device's identity and a port power grouping option from a small external EEPROM on a three-wire serial bus, once, right after reset. When the select input is low as reset ends, the reader generates the serial clock. It shifts out a read command for word address zero on the single shared data line, then turns the line around. It skips the one-bit gap the EEPROM inserts, and collects three consecutive 16-bit words in one burst. The EEPROM steps its own address from word to word. After the last bit it stops the clock, lets go of both pins, and raises a done flag.

The first word carries the grouping flag, the second the vendor ID and the third the product ID. When the select input is high as reset ends, the bus is never touched. The vendor and product IDs then come from parameters, and the grouping flag follows a board pin directly. Other logic may use the EEPROM once the reader has released it.

Top module: `cfg_rom_loader`

## Requirements
- R1: During reset and until the read or bypass decision has completed, `ld_done` is 0, `sclk_oe`, `sda_oe` and `sclk_o` are 0, and `vendor_id`, `product_id` and `gang_mode` are 0.
- R2: With `rom_sel_n` low on the first cycle after reset, the reader drives nine command bits on `sda_o`, one per serial clock period and stable across its rising edge: 1, 1, 0, then six zeros (start, read code, address 0).
- R3: `sda_oe` is 1 at each of the first nine rising edges of `sclk_o` and 0 from the tenth rising edge onward; the release happens at a falling edge.
- R4: `sda_i` is sampled at the end of each high phase of `sclk_o`; the bit after the ninth rising edge is a don't-care gap bit, and the next 48 bits form word 0, word 1, word 2 in that order, each most significant bit first.
- R5: After a read, `gang_mode` equals bit 14 of word 0, `vendor_id` equals word 1 and `product_id` equals word 2.
- R6: After exactly 57 serial clock periods `ld_done` rises and stays high; `sclk_oe` and `sda_oe` are 0 and `sclk_o` is low from then on.
- R7: The read happens only once per reset: later changes of `rom_sel_n` start no clock and alter no output.
- R8: With `rom_sel_n` high on the first cycle after reset, no serial clock is produced, `ld_done` rises, the IDs equal `DEF_VID` and `DEF_PID`, and `gang_mode` follows `gang_pin`.
- R9: The serial clock period is `CLK_DIV` system clocks, with the high phase lasting `CLK_DIV/2` of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_sel_n | input | 1 | Low at reset exit: read the EEPROM; high: use defaults |
| gang_pin | input | 1 | Grouping flag used when the EEPROM is not read |
| sda_i | input | 1 | Data line as seen from the pin |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock driver enable |
| sda_o | output | 1 | Data line value driven by the reader |
| sda_oe | output | 1 | Data line driver enable |
| ld_done | output | 1 | Identity outputs are valid |
| gang_mode | output | 1 | Ganged port power grouping flag |
| vendor_id | output | WORD_W | Vendor identifier |
| product_id | output | WORD_W | Product identifier |

## Verification
The bench builds the reader with `CLK_DIV` = 6 and non-default `DEF_VID`/`DEF_PID`. A whole 57-period read then takes a few hundred cycles, so many reads with random word contents fit in one run. The short divider also keeps the half-period sampling point only three cycles after the bench's EEPROM model changes the line, which exposes any off-by-one in the sampling edge. The changed default IDs show that bypass mode really takes them from the parameters.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;

  typedef enum logic [1:0] {
    ST_PICK  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } ld_state_e;

  // start bit + two opcode bits + address bits
  function automatic int unsigned cmd_len(input int unsigned addr_w);
    return 32'd3 + addr_w;
  endfunction

  // bits sent by the reader: 1 (start), 1 0 (read), then address 0
  function automatic logic cmd_bit(input int unsigned idx);
    return (idx < 32'd2);
  endfunction

  // total serial clock periods: command, gap bit overlaps last command period, data
  function automatic int unsigned total_periods(input int unsigned addr_w,
                                                input int unsigned n_words,
                                                input int unsigned word_w);
    return cmd_len(addr_w) + n_words * word_w;
  endfunction

endpackage

// File: rtl/cfgld_sclk_gen.sv
`timescale 1ns/1ps
module cfgld_sclk_gen #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_stb = run && (cnt == CW'(HALF - 1));
  assign fall_stb = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      if (rise_stb)      sclk <= 1'b1;
      else if (fall_stb) sclk <= 1'b0;
    end
  end

  // R9: the two edge strobes never coincide
  a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
  // R9: clock rests low whenever the reader is not running
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk);
  // R9: a rising strobe is followed by a high serial clock
  a_r9_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> sclk);
endmodule

// File: rtl/cfgld_capture.sv
`timescale 1ns/1ps
module cfgld_capture #(
  parameter int TOTAL_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [TOTAL_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data <= '0;
    else if (shift_en) data <= {data[TOTAL_W-2:0], din};
  end

  // R4: contents only move on a shift
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(data));
endmodule

// File: rtl/cfg_rom_loader.sv
`timescale 1ns/1ps
module cfg_rom_loader #(
  parameter int CLK_DIV  = 48,
  parameter int WORD_W   = 16,
  parameter int N_WORDS  = 3,
  parameter int ADDR_W   = 6,
  parameter int GANG_BIT = 14,
  parameter logic [WORD_W-1:0] DEF_VID = 16'h5A17,
  parameter logic [WORD_W-1:0] DEF_PID = 16'h0C07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rom_sel_n,
  input  logic              gang_pin,
  input  logic              sda_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              ld_done,
  output logic              gang_mode,
  output logic [WORD_W-1:0] vendor_id,
  output logic [WORD_W-1:0] product_id
);
  import cfgld_pkg::*;

  localparam int CMD_LEN  = int'(cmd_len(ADDR_W));
  localparam int DATA_LEN = N_WORDS * WORD_W;
  localparam int LAST_P   = int'(total_periods(ADDR_W, N_WORDS, WORD_W)) - 1;
  localparam int PW       = $clog2(LAST_P + 1);

  ld_state_e         state;
  logic [PW-1:0]     period;
  logic              bypass_q;
  logic              run;
  logic              rise_stb, fall_stb;
  logic              shift_en;
  logic [DATA_LEN-1:0] cap;
  logic [WORD_W-1:0] words [N_WORDS];

  assign run      = (state == ST_RUN);
  assign shift_en = run && fall_stb && (period >= PW'(CMD_LEN));

  cfgld_sclk_gen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  cfgld_capture #(.TOTAL_W(DATA_LEN)) u_cap (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sda_i), .data(cap)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    assign words[k] = cap[DATA_LEN-1-k*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PICK;
      period   <= '0;
      sda_o    <= 1'b0;
      sda_oe   <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      case (state)
        ST_PICK: begin
          if (!rom_sel_n) begin
            state  <= ST_RUN;
            period <= '0;
            sda_oe <= 1'b1;
            sda_o  <= cmd_bit(0);
          end else begin
            state    <= ST_FINAL;
            bypass_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (fall_stb) begin
            if (period == PW'(LAST_P)) begin
              state <= ST_FINAL;
            end else begin
              period <= period + 1'b1;
            end
            if (period == PW'(CMD_LEN - 1)) begin
              sda_oe <= 1'b0;
              sda_o  <= 1'b0;
            end else if (period < PW'(CMD_LEN - 1)) begin
              sda_o <= cmd_bit(32'(period) + 32'd1);
            end
          end
        end
        default: state <= ST_FINAL;
      endcase
    end
  end

  assign sclk_oe    = run;
  assign ld_done    = (state == ST_FINAL);
  assign gang_mode  = ld_done && (bypass_q ? gang_pin : words[0][GANG_BIT]);
  assign vendor_id  = ld_done ? (bypass_q ? DEF_VID : words[1]) : '0;
  assign product_id = ld_done ? (bypass_q ? DEF_PID : words[2]) : '0;

  // R3: the data line is only driven while the clock runs
  a_r3_drive_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> sclk_oe);
  // R3: the data line is released right after a falling strobe
  a_r3_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> $past(fall_stb));
  // R4: sampling never lands on a rising strobe
  a_r4_sample_not_rise: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !rise_stb);
  // R6: done is sticky and the pins stay released
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ld_done);
  a_r6_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (!sclk_oe && !sda_oe && !sclk_o));
  // R7: identifiers never change once valid
  a_r7_ids_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ($stable(vendor_id) && $stable(product_id)));
endmodule

// File: tb/sim_cfg_rom_loader.sv
`timescale 1ns/1ps
module sim_cfg_rom_loader;
  localparam int DIV = 6;
  localparam logic [15:0] VDEF = 16'hC0DE;
  localparam logic [15:0] PDEF = 16'h0B07;

  logic clk = 1'b0, rst_n = 1'b0, rom_sel_n = 1'b1, gang_pin = 1'b0, sda_i = 1'b0;
  logic sclk_o, sclk_oe, sda_o, sda_oe, ld_done, gang_mode;
  logic [15:0] vendor_id, product_id;

  int errors = 0, checks = 0;
  int cyc = 0, rises = 0, oe_bad = 0, rise0_cyc = 0, rise1_cyc = 0, fall0_cyc = 0;
  logic [8:0]  cmd_seen;
  logic [47:0] stream;

  cfg_rom_loader #(.CLK_DIV(DIV), .DEF_VID(VDEF), .DEF_PID(PDEF)) u0 (
    .clk(clk), .rst_n(rst_n), .rom_sel_n(rom_sel_n), .gang_pin(gang_pin),
    .sda_i(sda_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sda_o(sda_o),
    .sda_oe(sda_oe), .ld_done(ld_done), .gang_mode(gang_mode),
    .vendor_id(vendor_id), .product_id(product_id));

  always #5 clk = ~clk;
  initial forever begin @(posedge clk); cyc = cyc + 1; end

  // EEPROM model: updates the line after each rising serial clock edge
  initial forever begin
    @(posedge sclk_o); #1;
    if (rises < 9) begin
      cmd_seen = {cmd_seen[7:0], sda_o};
      if (!sda_oe) oe_bad = oe_bad + 1;
    end else if (sda_oe) oe_bad = oe_bad + 1;
    if (rises == 0) rise0_cyc = cyc;
    if (rises == 1) rise1_cyc = cyc;
    if (rises == 8)                    sda_i = 1'b0;           // gap bit
    else if (rises >= 9 && rises <= 56) sda_i = stream[47-(rises-9)];
    else                               sda_i = 1'b0;
    rises = rises + 1;
    if (rises == 1) begin @(negedge sclk_o); #1; fall0_cyc = cyc; end
  end

  function automatic logic [8:0] exp_cmd();
    return {1'b1, 2'b10, 6'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; rom_sel_n = sel;
    repeat (3) @(negedge clk);
    rises = 0; oe_bad = 0; cmd_seen = '0;
    chk(!ld_done && !sclk_oe && !sda_oe && !sclk_o, "R1 reset pins", {ld_done, sclk_oe, sda_oe, sclk_o}, 0);
    chk(vendor_id == 0 && product_id == 0 && !gang_mode, "R1 reset ids", vendor_id, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ld_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_read(input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    bit ok;
    stream = {w0, w1, w2};
    do_reset(1'b0);
    @(negedge clk);
    chk(!ld_done && vendor_id == 0, "R1 not done early", vendor_id, 0);
    wait_done(ok);
    chk(ok, "R6 done reached", ok, 1);
    chk(cmd_seen == exp_cmd(), "R2 command bits", cmd_seen, exp_cmd());
    chk(oe_bad == 0, "R3 data enable per edge", oe_bad, 0);
    chk(rises == 57, "R6 period count", rises, 57);
    chk(rise1_cyc - rise0_cyc == DIV, "R9 period", rise1_cyc - rise0_cyc, DIV);
    chk(fall0_cyc - rise0_cyc == DIV/2, "R9 high phase", fall0_cyc - rise0_cyc, DIV/2);
    chk(vendor_id == w1, "R5 vendor (R4 order)", vendor_id, w1);
    chk(product_id == w2, "R5 product (R4 order)", product_id, w2);
    chk(gang_mode == w0[14], "R5 ganged bit", gang_mode, w0[14]);
    chk(!sclk_oe && !sda_oe && !sclk_o, "R6 pins released", {sclk_oe, sda_oe, sclk_o}, 0);
    rom_sel_n = 1'b1; repeat (20) @(negedge clk);
    rom_sel_n = 1'b0; repeat (100) @(negedge clk);
    chk(rises == 57 && ld_done, "R7 no second read", rises, 57);
    chk(vendor_id == w1 && product_id == w2, "R7 ids kept", vendor_id, w1);
  endtask

  task automatic do_bypass();
    do_reset(1'b1);
    gang_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(ld_done, "R8 done", ld_done, 1);
    chk(vendor_id == VDEF, "R8 vendor default", vendor_id, VDEF);
    chk(product_id == PDEF, "R8 product default", product_id, PDEF);
    chk(gang_mode == 1'b0, "R8 gang low", gang_mode, 0);
    gang_pin = 1'b1; @(negedge clk);
    chk(gang_mode == 1'b1, "R8 gang follows pin", gang_mode, 1);
    rom_sel_n = 1'b0; repeat (100) @(negedge clk);
    chk(rises == 0 && !sclk_oe && !sda_oe, "R7 R8 no clock", rises, 0);
  endtask

  initial begin
    #2_000_000;
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h2077));
    do_bypass();
    do_read(16'h4000, 16'h0000, 16'hFFFF);
    do_read(16'hBFFF, 16'hFFFF, 16'h0000);
    do_read(16'hFFFF, 16'h8001, 16'h7FFE);
    for (int n = 0; n < 6; n++)
      do_read(16'($urandom), 16'($urandom), 16'($urandom));
    do_bypass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule